// File: doc/BRIEF.md
# Masked Status-Register Update Sequencer

This block changes selected bits of a serial flash device's two 8-bit status registers through an external byte-wide serial master. A caller supplies a 16-bit bit-select mask, a 16-bit target value and a persistence choice, then pulses start. The sequencer reads both registers and joins them into one word, with the first register in the low byte. If the selected bits already hold the target, it ends at once and writes nothing. Otherwise it enables writing, sends the merged word, waits for the device, reads both registers back and reports the outcome.

Every byte on the serial link is one request/acknowledge exchange. The sequencer raises a request with a byte to send and a flag that marks the last byte of a command. The external master answers with a one-cycle done pulse, the byte it received, and an error flag. The master releases chip select after each byte that carries the last-byte flag, so every command is framed on its own. A persistent update waits by polling the busy bit within a time limit. A volatile update waits a fixed deselect interval. When the run ends, exactly one of four outcome flags is raised (ok, locked, timeout, error), and the final status word is shown beside them.

Top module: `sreg_update_seq`

## Requirements
- R1: After start, the first two commands are read-status-low (opcode 0x05) and read-status-high (opcode 0x35). Each command is the opcode followed by one dummy byte. The reply to the first command forms bits 7:0 of the status word and the reply to the second forms bits 15:8.
- R2: If (status & mask) equals (value & mask), the run ends with ok set and the read word on the read-back output. No write-enable or write command is issued.
- R3: Otherwise the next command is a one-byte write enable. The opcode is 0x06 when the persistence input is 1 and 0x50 when it is 0.
- R4: A write-status command follows the write enable. It is opcode 0x01 followed by the low byte and then the high byte of (status & ~mask) | (value & mask).
- R5: After a persistent write, read-status-low (0x05) is repeated until reply bit 0 is 0. If bit 0 is still 1 after CLK_KHZ*POLL_MS cycles of polling, the run ends with timeout set and no read-back is issued.
- R6: After a volatile write, the transfer request stays low for at least ceil(CLK_KHZ*DESEL_NS/1e6) cycles (minimum 1) before the read-back begins.
- R7: The read-back repeats the R1 pair and drives the new word on the read-back output. Locked is set if any masked bit differs from the value, and ok is set otherwise.
- R8: A done pulse that carries the error flag ends the run at once with error set. No further request is made.
- R9: The last byte of every command carries the end flag and no other byte does. While a request waits for done, its byte and end flag do not change.
- R10: After reset the block is idle, with no request, no done and all outcome flags low.
- R11: A start pulse while the block is busy is ignored. The run in progress keeps its mask, value and persistence choice.
- R12: Done is a single-cycle pulse. While it is high, exactly one of ok, locked, timeout and error is set, and that flag holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an update (accepted only when idle) |
| mask_i | input | 16 | Bits to change |
| value_i | input | 16 | Target bit values |
| nonvol_i | input | 1 | 1 = persistent update, 0 = volatile update |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Run ended with the masked bits as requested |
| locked_o | output | 1 | Read-back disagreed with the request |
| timeout_o | output | 1 | Busy bit did not clear in time |
| error_o | output | 1 | A byte exchange reported an error |
| rdback_o | output | 16 | Last status word read |
| xfer_req_o | output | 1 | Byte exchange request |
| xfer_tx_o | output | 8 | Byte to send |
| xfer_end_o | output | 1 | Release chip select after this byte |
| xfer_done_i | input | 1 | Byte exchange finished |
| xfer_rx_i | input | 8 | Byte received |
| xfer_err_i | input | 1 | Byte exchange failed (valid with done) |

## Verification
The bench drives the sequencer against a behavioural flash model with per-bit write locks and a programmable number of busy polls.

The stimulus table covers four cases:
- a run that already matches, which must end with only the two reads;
- persistent and volatile writes, which are told apart by the enable opcode and by polling versus a silent gap;
- a run where locked bits make the read-back disagree;
- a run where every bit changes, which exposes any byte-order swap in assembly or write-back.

Directed runs cover:
- a device that never clears busy;
- an error injected on the second command;
- a second start arriving mid-run.

// File: rtl/srup_pkg.sv
package srup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDA_CMD,
    ST_RDA_DAT,
    ST_RDB_CMD,
    ST_RDB_DAT,
    ST_WREN,
    ST_WR_CMD,
    ST_WR_LO,
    ST_WR_HI,
    ST_DESEL,
    ST_POLL_CMD,
    ST_POLL_DAT
  } srup_state_e;

  typedef enum logic [1:0] {
    RES_OK,
    RES_LOCKED,
    RES_TIMEOUT,
    RES_ERROR
  } srup_res_e;

  localparam logic [7:0] OP_RD_LO   = 8'h05;
  localparam logic [7:0] OP_RD_HI   = 8'h35;
  localparam logic [7:0] OP_WREN_NV = 8'h06;
  localparam logic [7:0] OP_WREN_V  = 8'h50;
  localparam logic [7:0] OP_WRSR    = 8'h01;
  localparam logic [7:0] OP_DUMMY   = 8'h00;

endpackage

// File: rtl/srup_merge.sv
module srup_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] value_i,
  output logic [W-1:0] merged_o,
  output logic         match_o
);

  assign merged_o = (word_i & ~mask_i) | (value_i & mask_i);
  assign match_o  = ((word_i ^ value_i) & mask_i) == '0;

  // R2: when the selected bits already agree, the merge leaves the word unchanged
  always_comb begin
    if (match_o) begin
      p_merge_noop_r2: assert (merged_o == word_i);
    end
  end

endmodule

// File: rtl/srup_timer.sv
module srup_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | ~expired_o;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5/R6: once a window has run out it stays run out until reloaded
  p_expiry_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/sreg_update_seq.sv
module sreg_update_seq
  import srup_pkg::*;
#(
  parameter int CLK_KHZ  = 100_000,
  parameter int POLL_MS  = 30,
  parameter int DESEL_NS = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] mask_i,
  input  logic [15:0] value_i,
  input  logic        nonvol_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        ok_o,
  output logic        locked_o,
  output logic        timeout_o,
  output logic        error_o,
  output logic [15:0] rdback_o,
  output logic        xfer_req_o,
  output logic [7:0]  xfer_tx_o,
  output logic        xfer_end_o,
  input  logic        xfer_done_i,
  input  logic [7:0]  xfer_rx_i,
  input  logic        xfer_err_i
);

  localparam int POLL_CYC  = CLK_KHZ * POLL_MS;
  localparam int DESEL_RAW = (CLK_KHZ * DESEL_NS + 999_999) / 1_000_000;
  localparam int DESEL_CYC = (DESEL_RAW < 1) ? 1 : DESEL_RAW;
  localparam int TMR_MAX   = (POLL_CYC > DESEL_CYC) ? POLL_CYC : DESEL_CYC;
  localparam int TW        = $clog2(TMR_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  srup_state_e state_q, state_d;
  logic [15:0] cur_q, cur_d;
  logic [15:0] mask_q, value_q;
  logic        nonvol_q;
  logic        verify_q, verify_d;
  logic        cap_cfg;

  logic        fin;
  srup_res_e   fin_res;
  logic [15:0] fin_word;

  logic        tmr_load;
  logic [TW-1:0] tmr_val;
  logic        tmr_exp;

  logic [15:0] cmp_word;
  logic [15:0] merged;
  logic        match;
  logic        xfer_ok;
  logic        xfer_bad;

  logic        done_q, ok_q, locked_q, tout_q, err_q;
  logic [15:0] rdback_q;
  logic        flag_en;

  assign cmp_word = (state_q == ST_RDB_DAT) ? {xfer_rx_i, cur_q[7:0]} : cur_q;

  srup_merge #(.W(16)) u_merge (
    .word_i   (cmp_word),
    .mask_i   (mask_q),
    .value_i  (value_q),
    .merged_o (merged),
    .match_o  (match)
  );

  srup_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  // byte request decode
  always_comb begin
    xfer_req_o = 1'b1;
    xfer_tx_o  = OP_DUMMY;
    xfer_end_o = 1'b0;
    unique case (state_q)
      ST_RDA_CMD:  xfer_tx_o = OP_RD_LO;
      ST_RDA_DAT:  xfer_end_o = 1'b1;
      ST_RDB_CMD:  xfer_tx_o = OP_RD_HI;
      ST_RDB_DAT:  xfer_end_o = 1'b1;
      ST_WREN: begin
        xfer_tx_o  = nonvol_q ? OP_WREN_NV : OP_WREN_V;
        xfer_end_o = 1'b1;
      end
      ST_WR_CMD:   xfer_tx_o = OP_WRSR;
      ST_WR_LO:    xfer_tx_o = merged[7:0];
      ST_WR_HI: begin
        xfer_tx_o  = merged[15:8];
        xfer_end_o = 1'b1;
      end
      ST_POLL_CMD: xfer_tx_o = OP_RD_LO;
      ST_POLL_DAT: xfer_end_o = 1'b1;
      default:     xfer_req_o = 1'b0;
    endcase
  end

  assign xfer_ok  = xfer_req_o & xfer_done_i & ~xfer_err_i;
  assign xfer_bad = xfer_req_o & xfer_done_i &  xfer_err_i;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    verify_d = verify_q;
    cap_cfg  = 1'b0;
    fin      = 1'b0;
    fin_res  = RES_OK;
    fin_word = cur_q;
    tmr_load = 1'b0;
    tmr_val  = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_cfg  = 1'b1;
          verify_d = 1'b0;
          state_d  = ST_RDA_CMD;
        end
      end
      ST_RDA_CMD: if (xfer_ok) state_d = ST_RDA_DAT;
      ST_RDA_DAT: begin
        if (xfer_ok) begin
          cur_d[7:0] = xfer_rx_i;
          state_d    = ST_RDB_CMD;
        end
      end
      ST_RDB_CMD: if (xfer_ok) state_d = ST_RDB_DAT;
      ST_RDB_DAT: begin
        if (xfer_ok) begin
          cur_d[15:8] = xfer_rx_i;
          if (verify_q) begin
            fin      = 1'b1;
            fin_res  = match ? RES_OK : RES_LOCKED;
            fin_word = cmp_word;
          end else if (match) begin
            fin      = 1'b1;
            fin_res  = RES_OK;
            fin_word = cmp_word;
          end else begin
            state_d = ST_WREN;
          end
        end
      end
      ST_WREN:   if (xfer_ok) state_d = ST_WR_CMD;
      ST_WR_CMD: if (xfer_ok) state_d = ST_WR_LO;
      ST_WR_LO:  if (xfer_ok) state_d = ST_WR_HI;
      ST_WR_HI: begin
        if (xfer_ok) begin
          tmr_load = 1'b1;
          if (nonvol_q) begin
            tmr_val = TW'(POLL_CYC);
            state_d = ST_POLL_CMD;
          end else begin
            tmr_val = TW'(DESEL_CYC);
            state_d = ST_DESEL;
          end
        end
      end
      ST_DESEL: begin
        if (tmr_exp) begin
          verify_d = 1'b1;
          state_d  = ST_RDA_CMD;
        end
      end
      ST_POLL_CMD: if (xfer_ok) state_d = ST_POLL_DAT;
      ST_POLL_DAT: begin
        if (xfer_ok) begin
          if (!xfer_rx_i[0]) begin
            verify_d = 1'b1;
            state_d  = ST_RDA_CMD;
          end else if (tmr_exp) begin
            fin     = 1'b1;
            fin_res = RES_TIMEOUT;
          end else begin
            state_d = ST_POLL_CMD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (xfer_bad) begin
      fin      = 1'b1;
      fin_res  = RES_ERROR;
      fin_word = cur_q;
    end
    if (fin) state_d = ST_IDLE;
  end

  // state and working registers
  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      verify_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      verify_q <= verify_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) begin
      mask_q   <= '0;
      value_q  <= '0;
      nonvol_q <= 1'b0;
    end else if (cap_cfg) begin
      mask_q   <= mask_i;
      value_q  <= value_i;
      nonvol_q <= nonvol_i;
    end
  end

  // outcome registers
  assign flag_en = cap_cfg | fin;

  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) done_q <= 1'b0;
    else        done_q <= fin;
  end

  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) begin
      ok_q     <= 1'b0;
      locked_q <= 1'b0;
      tout_q   <= 1'b0;
      err_q    <= 1'b0;
      rdback_q <= '0;
    end else if (flag_en) begin
      ok_q     <= fin & (fin_res == RES_OK);
      locked_q <= fin & (fin_res == RES_LOCKED);
      tout_q   <= fin & (fin_res == RES_TIMEOUT);
      err_q    <= fin & (fin_res == RES_ERROR);
      if (fin) rdback_q <= fin_word;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign locked_o  = locked_q;
  assign timeout_o = tout_q;
  assign error_o   = err_q;
  assign rdback_o  = rdback_q;

  // R9: a pending byte request holds its byte and framing until acknowledged
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_i)
    (xfer_req_o && !xfer_done_i) |=>
      (xfer_req_o && $stable(xfer_tx_o) && $stable(xfer_end_o)));

  // R10: no traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_i)
    !busy_o |-> !xfer_req_o);

  // R8: an errored exchange ends the run on the next cycle
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_i)
    xfer_bad |=> (done_o && error_o && !busy_o));

  // R12: done lasts one cycle and carries exactly one outcome
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_i)
    done_o |=> !done_o);
  p_done_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_i)
    done_o |-> ($countones({ok_o, locked_o, timeout_o, error_o}) == 1));

  // R11: a start while busy leaves the captured request untouched
  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_i)
    (busy_o && start_i) |=> ($stable(mask_q) && $stable(value_q) && $stable(nonvol_q)));

endmodule

// File: tb/test_sreg_update_seq.sv
module test_sreg_update_seq;

  localparam int CLK_KHZ  = 1000;
  localparam int POLL_MS  = 2;
  localparam int DESEL_NS = 5000;
  localparam int DESEL_CYC = 5;
  localparam int LAT = 2;

  typedef struct packed {
    logic [15:0] init;
    logic [15:0] mask;
    logic [15:0] val;
    logic [15:0] lockm;
    logic        nv;
    logic [19:0] busy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h007C, 16'h0024, 16'h0000, 1'b1, 20'd3},
    '{16'h0024, 16'h007C, 16'h0024, 16'h0000, 1'b1, 20'd0},
    '{16'h1234, 16'h4000, 16'h4000, 16'h0000, 1'b0, 20'd0},
    '{16'h0080, 16'h4180, 16'h4100, 16'h0180, 1'b1, 20'd1},
    '{16'hFFFE, 16'hFFFE, 16'h0000, 16'h0000, 1'b0, 20'd0},
    '{16'hA5A4, 16'h00FF, 16'h00A4, 16'h0000, 1'b0, 20'd0}
  };

  logic clk, rst_n;
  logic start, nonvol;
  logic [15:0] mask, value;
  logic busy, done, ok, locked, tout, err;
  logic [15:0] rdback;
  logic xfer_req, xfer_end, xfer_done, xfer_err;
  logic [7:0] xfer_tx, xfer_rx;

  int n_checks = 0;
  int n_fail = 0;

  sreg_update_seq #(.CLK_KHZ(CLK_KHZ), .POLL_MS(POLL_MS), .DESEL_NS(DESEL_NS)) i_sreg_update_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mask_i(mask), .value_i(value),
    .nonvol_i(nonvol), .busy_o(busy), .done_o(done), .ok_o(ok), .locked_o(locked),
    .timeout_o(tout), .error_o(err), .rdback_o(rdback), .xfer_req_o(xfer_req),
    .xfer_tx_o(xfer_tx), .xfer_end_o(xfer_end), .xfer_done_i(xfer_done),
    .xfer_rx_i(xfer_rx), .xfer_err_i(xfer_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // flash device model
  logic [15:0] sr, lockm;
  int busy_cfg, busy_left, err_at, byte_idx, pos, nops, nends, gap, lat;
  logic [7:0] op, wlo, whi;
  logic [7:0] ops [512];
  logic wel, vwel, measuring;

  always @(negedge clk) begin
    if (measuring) begin
      if (xfer_req) measuring = 1'b0;
      else gap++;
    end
    if (xfer_done) begin
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
    end else if (xfer_req) begin
      if (lat < LAT) lat++;
      else begin
        lat = 0;
        xfer_rx  = 8'h00;
        xfer_err = (byte_idx == err_at);
        byte_idx++;
        if (pos == 0) begin
          op = xfer_tx;
          if (nops < 512) ops[nops] = xfer_tx;
          nops++;
          if (xfer_tx == 8'h06) wel = 1'b1;
          if (xfer_tx == 8'h50) vwel = 1'b1;
        end else begin
          case (op)
            8'h05: begin
              xfer_rx = sr[7:0] | {7'd0, busy_left > 0};
              if (busy_left > 0) busy_left--;
            end
            8'h35: xfer_rx = sr[15:8];
            8'h01: begin
              if (pos == 1) wlo = xfer_tx;
              if (pos == 2) whi = xfer_tx;
            end
            default: ;
          endcase
        end
        if (xfer_end) begin
          nends++;
          if (op == 8'h01 && pos == 2 && (wel || vwel)) begin
            sr = (sr & lockm) | ({whi, wlo} & ~lockm);
            if (wel) busy_left = busy_cfg;
            measuring = 1'b1;
            gap = 0;
          end
          if (op == 8'h01) begin
            wel = 1'b0;
            vwel = 1'b0;
          end
          pos = 0;
        end else pos++;
        xfer_done = 1'b1;
      end
    end
  end

  task automatic chk(input logic cond, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic prep(input logic [15:0] init, input logic [15:0] lk, input int bz, input int ea);
    sr = init; lockm = lk; busy_cfg = bz; busy_left = 0; err_at = ea;
    byte_idx = 0; pos = 0; nops = 0; nends = 0; gap = 0; lat = 0;
    wel = 1'b0; vwel = 1'b0; measuring = 1'b0; wlo = 8'h00; whi = 8'h00;
  endtask

  task automatic kick(input logic [15:0] m, input logic [15:0] v, input logic nv);
    @(negedge clk);
    mask = m; value = v; nonvol = nv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) chk(1'b0, "watchdog: done never seen", 32'(wd), 32'd20000);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done, "R12 done is a single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    start = 1'b0; mask = '0; value = '0; nonvol = 1'b0;
    xfer_done = 1'b0; xfer_err = 1'b0; xfer_rx = 8'h00; op = 8'h00;
    prep(16'h0000, 16'h0000, 0, -1);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(!busy && !xfer_req && !done, "R10 idle after reset", {29'd0, busy, xfer_req, done}, 32'd0);
    chk({ok, locked, tout, err} == 4'b0, "R10 flags clear after reset", 32'({ok, locked, tout, err}), 32'd0);

    // table-driven runs
    for (int i = 0; i < NV; i++) begin
      logic [15:0] mg, res, rd;
      logic skip, lk;
      vec_t t;
      t = VECS[i];
      skip = ((t.init ^ t.val) & t.mask) == 16'h0;
      mg   = (t.init & ~t.mask) | (t.val & t.mask);
      res  = (t.init & t.lockm) | (mg & ~t.lockm);
      lk   = ((res ^ t.val) & t.mask) != 16'h0;
      rd   = skip ? t.init : res;
      prep(t.init, t.lockm, int'(t.busy), -1);
      kick(t.mask, t.val, t.nv);
      wait_done();
      chk(ops[0] == 8'h05 && ops[1] == 8'h35, "R1 read order", {ops[0], ops[1]}, 32'h0535);
      chk(rdback == rd, "R1/R7 read-back word", 32'(rdback), 32'(rd));
      chk(ok == (skip || !lk) && locked == (!skip && lk), "R7 outcome flag",
          {28'd0, ok, locked, tout, err}, {28'd0, (skip || !lk), (!skip && lk), 2'b00});
      chk(nends == nops, "R9 every command framed", 32'(nends), 32'(nops));
      if (skip) begin
        chk(nops == 2, "R2 no write when matching", 32'(nops), 32'd2);
      end else begin
        chk(ops[2] == (t.nv ? 8'h06 : 8'h50), "R3 write-enable opcode", 32'(ops[2]), t.nv ? 32'h06 : 32'h50);
        chk(ops[3] == 8'h01 && {whi, wlo} == mg, "R4 write command and bytes", {ops[3], whi, wlo}, {8'h01, mg});
        chk(ops[nops-2] == 8'h05 && ops[nops-1] == 8'h35, "R7 read-back pair", {ops[nops-2], ops[nops-1]}, 32'h0535);
        if (t.nv) chk(nops - 6 == int'(t.busy) + 1, "R5 poll count", 32'(nops - 6), 32'(t.busy + 1));
        else begin
          chk(nops == 6, "R6 no polling when volatile", 32'(nops), 32'd6);
          chk(gap >= DESEL_CYC, "R6 deselect gap", 32'(gap), DESEL_CYC);
        end
      end
      after_done();
    end

    // R5 timeout: device never clears busy
    prep(16'h0000, 16'h0000, 100000, -1);
    kick(16'h0004, 16'h0004, 1'b1);
    wait_done();
    chk(tout && !ok && !locked && !err, "R5 timeout flag", {28'd0, ok, locked, tout, err}, 32'h2);
    chk(ops[nops-1] == 8'h05, "R5 no read-back after timeout", 32'(ops[nops-1]), 32'h05);
    after_done();

    // R8 error on the second command's opcode byte
    prep(16'h0000, 16'h0000, 0, 2);
    kick(16'h0004, 16'h0004, 1'b1);
    wait_done();
    chk(err && !ok, "R8 error flag", {28'd0, ok, locked, tout, err}, 32'h1);
    repeat (20) @(negedge clk);
    chk(nops == 2 && !xfer_req, "R8 no traffic after abort", 32'(nops), 32'd2);

    // R11 start while busy is ignored
    prep(16'h0000, 16'h0000, 0, -1);
    kick(16'h00FF, 16'h0011, 1'b0);
    repeat (8) @(negedge clk);
    kick(16'hFF00, 16'hFF00, 1'b1);
    wait_done();
    chk(ok && rdback == 16'h0011, "R11 mid-run start ignored", 32'(rdback), 32'h0011);
    chk(ops[2] == 8'h50, "R11 first request kept", 32'(ops[2]), 32'h50);
    // R12 flags hold until next start
    repeat (5) @(negedge clk);
    chk(ok && rdback == 16'h0011, "R12 outcome held", 32'(rdback), 32'h0011);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule